// File: doc/BRIEF.md
# External Bus Slow Chip-Select Controller

This block masters a narrow asynchronous external memory bus that is shared by six devices. A requester hands it one access at a time: a direction, a chip-select index, a 9-bit address and, for writes, a 16-bit word. The block plays that access out on the bus pins: address, address-valid strobe, one active-low chip select, output enable or write enable, and the write data path. A read ends with the captured word and a one-cycle valid pulse.

Every chip select has its own timing settings, given on static configuration pins:
- wait cycles per access, for each direction;
- an initial latency for the first access of a run to a page or burst memory, for each direction;
- write hold cycles;
- bus-turnaround recovery cycles.

A chip select may also be marked fast. It then delays its strobe after the address-valid cycle by an address-hold bit, an enable delay and a read lead time.

The 16-bit data bus is split at this boundary into an output word, an output enable and an input word. Pads outside the block combine the three into the bidirectional pins.

The request interface is valid/ready. `req_ready` is high only while no access is in progress. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the requester must hold the request steady. There is no back-pressure on read data, so `rd_valid` is a single-cycle pulse that must be consumed when it appears.

Top module: `xbus_slow_cs_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. It goes low in the cycle after a request is accepted and stays low until that access completes. A request is taken only on an edge where `req_valid` and `req_ready` are both high.
- R2: An access drives only the addressed chip select low, and at most one select is ever low. `bus_addr` carries the request address throughout the access. `bus_avalid_n` is low for exactly one cycle, the first cycle in which the chip select is low.
- R3: A read holds `bus_oe_n` low for 1 + read-wait cycles, plus read-delta when it is a first access. The word on `bus_dq_i` in the last such cycle appears on `rd_data`, with `rd_valid` high for one cycle in the next cycle. `req_ready` is high again in that same cycle.
- R4: A write holds `bus_we_n` low for 1 + write-wait cycles, plus write-delta when it is a first access. The chip select then stays low with `bus_we_n` high for write-hold + 1 further cycles, so a setting of 0 still gives one hold cycle.
- R5: `bus_dq_oe` is high, with `bus_dq_o` equal to the write word, from the first cycle of `bus_we_n` low until the chip select rises. It is low in every other cycle, and never high while `bus_oe_n` is low.
- R6: An access counts as a first access when any of these holds: no access has happened since reset, its chip select differs from the previous access, its address bits [8:2] differ from the previous access, or its direction differs from the previous access.
- R7: After a read, an access to another chip select, or a write to the same chip select, is preceded by recovery cycles. All selects stay high during them. Their number is the recovery setting of the chip select that was read, plus 1, so a setting of 0 still gives one cycle.
- R8: No recovery cycles are inserted after a write, or between two reads of the same chip select.
- R9: On a fast chip select, a read waits G cycles after the address-valid cycle before `bus_oe_n` goes low. G is the larger of the read lead setting and the sum of the enable delay and the address-hold bit. A slow chip select has no such gap.
- R10: On a fast chip select, a write with the address-hold bit set has one cycle between the address-valid cycle and `bus_we_n` going low. With the bit clear, there is no such cycle.
- R11: While `rst_n` is low, and after reset is released, all chip selects, `bus_oe_n`, `bus_we_n` and `bus_avalid_n` are high, `bus_dq_oe` and `rd_valid` are low, and `req_ready` is high. Reset also forgets the access history, so the next access is a first access with no recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Chip-select index, 0 to 5 |
| req_addr | input | 9 | Word address on the bus |
| req_wdata | input | 16 | Write word |
| rd_valid | output | 1 | One-cycle pulse, read word valid |
| rd_data | output | 16 | Captured read word |
| cfg_fast | input | 6 | Per select: fast timing mode |
| cfg_addr_hold | input | 6 | Per select: extra address-hold cycle (fast) |
| cfg_oe_dly | input | 12 | Per select, 2 bits: enable delay after address valid (fast) |
| cfg_rd_lead | input | 24 | Per select, 4 bits: select-to-enable lead for reads (fast) |
| cfg_recovery | input | 24 | Per select, 4 bits: recovery setting |
| cfg_wr_hold | input | 24 | Per select, 4 bits: write hold setting |
| cfg_wr_wait | input | 24 | Per select, 4 bits: write wait cycles |
| cfg_rd_wait | input | 24 | Per select, 4 bits: read wait cycles |
| cfg_wr_delta | input | 48 | Per select, 8 bits: first-write latency |
| cfg_rd_delta | input | 48 | Per select, 8 bits: first-read latency |
| bus_addr | output | 9 | Address pins |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_avalid_n | output | 1 | Active-low address valid |
| bus_dq_o | output | 16 | Data toward the pads |
| bus_dq_oe | output | 1 | Pad output enable for data |
| bus_dq_i | input | 16 | Data from the pads |

## Verification
A wrong phase counter or a wrong length load shows at once as a strobe that is one or more cycles too long or too short, and as a shift in the cycle where `req_ready` or `rd_valid` returns, within the same access. Errors in the page and history compare do not change the current access. They show only on the next access, as a missing or extra initial latency, or as recovery cycles that are missing or should not be there. The bench therefore runs access chains that cross pages, change direction and change chip select, and measures every strobe width and every gap. A history that survives reset shows as a missing latency on the first access after a reset in the middle of an access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int SHORT_W = 4;   // wait, hold, recovery, read-lead fields
  localparam int DELTA_W = 8;   // first-access latency fields
  localparam int OEDLY_W = 2;   // fast-mode enable delay field

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECOV,
    ST_SETUP,
    ST_GAP,
    ST_ACCESS,
    ST_HOLD
  } xbus_state_e;

  typedef struct packed {
    logic               fast;
    logic               addr_hold;
    logic [OEDLY_W-1:0] oe_dly;
    logic [SHORT_W-1:0] rd_lead;
    logic [SHORT_W-1:0] wr_hold;
    logic [SHORT_W-1:0] wr_wait;
    logic [SHORT_W-1:0] rd_wait;
    logic [DELTA_W-1:0] wr_delta;
    logic [DELTA_W-1:0] rd_delta;
  } xbus_cs_cfg_t;

endpackage

// File: rtl/xbus_cfg_sel.sv
module xbus_cfg_sel
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0]           sel,
  input  logic [NUM_CS-1:0]          cfg_fast,
  input  logic [NUM_CS-1:0]          cfg_addr_hold,
  input  logic [NUM_CS*OEDLY_W-1:0]  cfg_oe_dly,
  input  logic [NUM_CS*SHORT_W-1:0]  cfg_rd_lead,
  input  logic [NUM_CS*SHORT_W-1:0]  cfg_wr_hold,
  input  logic [NUM_CS*SHORT_W-1:0]  cfg_wr_wait,
  input  logic [NUM_CS*SHORT_W-1:0]  cfg_rd_wait,
  input  logic [NUM_CS*DELTA_W-1:0]  cfg_wr_delta,
  input  logic [NUM_CS*DELTA_W-1:0]  cfg_rd_delta,
  output xbus_cs_cfg_t               cfg
);

  localparam int TBL_N = 1 << SEL_W;

  xbus_cs_cfg_t tbl [TBL_N];

  // Unpack the flat per-select fields; unused slots read as all-zero timing.
  for (genvar i = 0; i < TBL_N; i++) begin : g_unpack
    if (i < NUM_CS) begin : g_real
      assign tbl[i] = '{
        fast:      cfg_fast[i],
        addr_hold: cfg_addr_hold[i],
        oe_dly:    cfg_oe_dly[i*OEDLY_W +: OEDLY_W],
        rd_lead:   cfg_rd_lead[i*SHORT_W +: SHORT_W],
        wr_hold:   cfg_wr_hold[i*SHORT_W +: SHORT_W],
        wr_wait:   cfg_wr_wait[i*SHORT_W +: SHORT_W],
        rd_wait:   cfg_rd_wait[i*SHORT_W +: SHORT_W],
        wr_delta:  cfg_wr_delta[i*DELTA_W +: DELTA_W],
        rd_delta:  cfg_rd_delta[i*DELTA_W +: DELTA_W]
      };
    end else begin : g_pad
      assign tbl[i] = '0;
    end
  end

  assign cfg = tbl[sel];

endmodule

// File: rtl/xbus_hist_track.sv
module xbus_hist_track #(
  parameter int SEL_W  = 3,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_cs,
  input  logic [PAGE_W-1:0] req_page,
  output logic              first_acc,
  output logic              need_recov,
  output logic [SEL_W-1:0]  prev_cs
);

  logic              hist_v;
  logic              prev_wr;
  logic [PAGE_W-1:0] prev_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_v    <= 1'b0;
      prev_wr   <= 1'b0;
      prev_cs   <= '0;
      prev_page <= '0;
    end else if (accept) begin
      hist_v    <= 1'b1;
      prev_wr   <= req_write;
      prev_cs   <= req_cs;
      prev_page <= req_page;
    end
  end

  logic cs_change;
  assign cs_change = (req_cs != prev_cs);

  // Initial latency re-arms on any change of select, page or direction.
  assign first_acc  = !hist_v || cs_change || (req_page != prev_page) ||
                      (req_write != prev_wr);
  // Turnaround only after a read: another select, or a write to the same one.
  assign need_recov = hist_v && !prev_wr && (cs_change || req_write);

endmodule

// File: rtl/xbus_phase_engine.sv
module xbus_phase_engine
  import xbus_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               acc_first,
  input  logic               acc_recov,
  input  logic [SHORT_W-1:0] recov_set,
  input  logic               cur_wr,
  input  xbus_cs_cfg_t       cfg,
  output logic               idle,
  output logic               cs_act,
  output logic               adv,
  output logic               strobe,
  output logic               hold,
  output logic               rd_done
);

  xbus_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             first_q;
  logic [CNT_W-1:0] gap_len;
  logic [CNT_W-1:0] rd_path;
  logic [CNT_W-1:0] acc_extra;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_comb begin
    rd_path = CNT_W'(cfg.oe_dly) + CNT_W'(cfg.addr_hold);
    gap_len = '0;
    if (cfg.fast) begin
      if (cur_wr) gap_len = CNT_W'(cfg.addr_hold);
      else        gap_len = (CNT_W'(cfg.rd_lead) > rd_path) ? CNT_W'(cfg.rd_lead) : rd_path;
    end
    if (cur_wr)
      acc_extra = CNT_W'(cfg.wr_wait) + (first_q ? CNT_W'(cfg.wr_delta) : '0);
    else
      acc_extra = CNT_W'(cfg.rd_wait) + (first_q ? CNT_W'(cfg.rd_delta) : '0);
  end

  // One down-counter serves every phase; a phase ends when it reads zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          first_q <= acc_first;
          if (acc_recov) begin
            st  <= ST_RECOV;
            cnt <= CNT_W'(recov_set);
          end else begin
            st  <= ST_SETUP;
            cnt <= '0;
          end
        end
        ST_RECOV: begin
          if (cnt_zero) st <= ST_SETUP;
          else          cnt <= cnt - 1'b1;
        end
        ST_SETUP: begin
          if (gap_len != '0) begin
            st  <= ST_GAP;
            cnt <= gap_len - 1'b1;
          end else begin
            st  <= ST_ACCESS;
            cnt <= acc_extra;
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            st  <= ST_ACCESS;
            cnt <= acc_extra;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACCESS: begin
          if (cnt_zero) begin
            if (cur_wr) begin
              st  <= ST_HOLD;
              cnt <= CNT_W'(cfg.wr_hold);
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_zero) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st == ST_IDLE);
  assign adv     = (st == ST_SETUP);
  assign strobe  = (st == ST_ACCESS);
  assign hold    = (st == ST_HOLD);
  assign cs_act  = adv || (st == ST_GAP) || strobe || hold;
  assign rd_done = strobe && cnt_zero && !cur_wr;

endmodule

// File: rtl/xbus_slow_cs_ctrl.sv
module xbus_slow_cs_ctrl
  import xbus_pkg::*;
#(
  parameter int NUM_CS   = 6,
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 16,
  parameter int PAGE_LSB = 2,
  parameter int SEL_W    = $clog2(NUM_CS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [SEL_W-1:0]          req_cs,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [NUM_CS-1:0]         cfg_fast,
  input  logic [NUM_CS-1:0]         cfg_addr_hold,
  input  logic [NUM_CS*OEDLY_W-1:0] cfg_oe_dly,
  input  logic [NUM_CS*SHORT_W-1:0] cfg_rd_lead,
  input  logic [NUM_CS*SHORT_W-1:0] cfg_recovery,
  input  logic [NUM_CS*SHORT_W-1:0] cfg_wr_hold,
  input  logic [NUM_CS*SHORT_W-1:0] cfg_wr_wait,
  input  logic [NUM_CS*SHORT_W-1:0] cfg_rd_wait,
  input  logic [NUM_CS*DELTA_W-1:0] cfg_wr_delta,
  input  logic [NUM_CS*DELTA_W-1:0] cfg_rd_delta,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [NUM_CS-1:0]         bus_cs_n,
  output logic                      bus_oe_n,
  output logic                      bus_we_n,
  output logic                      bus_avalid_n,
  output logic [DATA_W-1:0]         bus_dq_o,
  output logic                      bus_dq_oe,
  input  logic [DATA_W-1:0]         bus_dq_i
);

  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int CNT_W  = $clog2((1 << DELTA_W) + (1 << SHORT_W) + 1);

  logic              accept;
  logic              cur_wr;
  logic [SEL_W-1:0]  cur_cs;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  logic              first_acc, need_recov;
  logic [SEL_W-1:0]  prev_cs;
  logic [SHORT_W-1:0] recov_set;
  xbus_cs_cfg_t      cur_cfg;

  logic eng_idle, eng_cs, eng_adv, eng_strobe, eng_hold, eng_rd_done;

  assign req_ready = eng_idle;
  assign accept    = req_valid && eng_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wr    <= 1'b0;
      cur_cs    <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_wr    <= req_write;
      cur_cs    <= req_cs;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  xbus_hist_track #(.SEL_W(SEL_W), .PAGE_W(PAGE_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .req_page   (req_addr[ADDR_W-1:PAGE_LSB]),
    .first_acc  (first_acc),
    .need_recov (need_recov),
    .prev_cs    (prev_cs)
  );

  // Recovery length belongs to the select that was just read.
  assign recov_set = cfg_recovery[prev_cs*SHORT_W +: SHORT_W];

  xbus_cfg_sel #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cfg (
    .sel           (cur_cs),
    .cfg_fast      (cfg_fast),
    .cfg_addr_hold (cfg_addr_hold),
    .cfg_oe_dly    (cfg_oe_dly),
    .cfg_rd_lead   (cfg_rd_lead),
    .cfg_wr_hold   (cfg_wr_hold),
    .cfg_wr_wait   (cfg_wr_wait),
    .cfg_rd_wait   (cfg_rd_wait),
    .cfg_wr_delta  (cfg_wr_delta),
    .cfg_rd_delta  (cfg_rd_delta),
    .cfg           (cur_cfg)
  );

  xbus_phase_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .acc_first (first_acc),
    .acc_recov (need_recov),
    .recov_set (recov_set),
    .cur_wr    (cur_wr),
    .cfg       (cur_cfg),
    .idle      (eng_idle),
    .cs_act    (eng_cs),
    .adv       (eng_adv),
    .strobe    (eng_strobe),
    .hold      (eng_hold),
    .rd_done   (eng_rd_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= eng_rd_done;
      if (eng_rd_done) rd_data <= bus_dq_i;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign bus_cs_n[i] = !(eng_cs && (cur_cs == SEL_W'(i)));
  end

  assign bus_addr     = cur_addr;
  assign bus_avalid_n = !eng_adv;
  assign bus_oe_n     = !(eng_strobe && !cur_wr);
  assign bus_we_n     = !(eng_strobe && cur_wr);
  assign bus_dq_oe    = cur_wr && (eng_strobe || eng_hold);
  assign bus_dq_o     = cur_wdata;

endmodule

// File: rtl/xbus_slow_cs_chk.sv
module xbus_slow_cs_chk #(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_we_n,
  input logic              bus_avalid_n,
  input logic              bus_dq_oe
);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n == '1 && bus_oe_n && bus_we_n));

  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  a_r2_avalid_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_avalid_n |-> (bus_cs_n != '1));

  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> bus_we_n);

  a_r4_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> (bus_dq_oe && bus_cs_n != '1));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_dq_oe);

  a_r5_drive_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dq_oe |-> (bus_cs_n != '1));

endmodule

bind xbus_slow_cs_ctrl xbus_slow_cs_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rd_valid     (rd_valid),
  .bus_cs_n     (bus_cs_n),
  .bus_oe_n     (bus_oe_n),
  .bus_we_n     (bus_we_n),
  .bus_avalid_n (bus_avalid_n),
  .bus_dq_oe    (bus_dq_oe)
);

// File: tb/tb_xbus_slow_cs_ctrl.sv
module tb_xbus_slow_cs_ctrl;

  localparam int NCS = 6;

  // Per-select settings: index = chip select
  localparam int REC_C [NCS] = '{2, 0, 1, 3, 0, 4};
  localparam int WH_C  [NCS] = '{1, 0, 0, 2, 0, 0};
  localparam int WW_C  [NCS] = '{2, 0, 1, 0, 1, 0};
  localparam int RW_C  [NCS] = '{3, 0, 1, 0, 0, 2};
  localparam int WD_C  [NCS] = '{5, 0, 0, 1, 2, 0};
  localparam int RD_C  [NCS] = '{4, 0, 2, 1, 0, 0};
  localparam int FAST_C[NCS] = '{0, 0, 1, 1, 0, 0};
  localparam int AH_C  [NCS] = '{0, 0, 1, 0, 0, 0};
  localparam int OED_C [NCS] = '{0, 0, 2, 0, 0, 0};
  localparam int RL_C  [NCS] = '{0, 0, 1, 3, 0, 0};

  typedef struct packed {
    logic        wr;
    logic [2:0]  cs;
    logic [8:0]  addr;
    logic [15:0] data;
    logic        first;
    logic        rec;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 3'd0, 9'h010, 16'h0000, 1'b1, 1'b0},
    '{1'b0, 3'd0, 9'h011, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 3'd0, 9'h012, 16'hA5C3, 1'b1, 1'b1},
    '{1'b1, 3'd0, 9'h013, 16'h1234, 1'b0, 1'b0},
    '{1'b1, 3'd0, 9'h020, 16'hFFFF, 1'b1, 1'b0},
    '{1'b0, 3'd1, 9'h020, 16'h0000, 1'b1, 1'b0},
    '{1'b0, 3'd2, 9'h1F0, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 3'd2, 9'h1F1, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 3'd2, 9'h1F2, 16'h0F0F, 1'b1, 1'b1},
    '{1'b0, 3'd3, 9'h005, 16'h0000, 1'b1, 1'b0},
    '{1'b0, 3'd5, 9'h100, 16'h0000, 1'b1, 1'b1},
    '{1'b1, 3'd4, 9'h0AA, 16'h8001, 1'b1, 1'b1},
    '{1'b1, 3'd4, 9'h0AB, 16'h7E7E, 1'b0, 1'b0},
    '{1'b0, 3'd4, 9'h0AB, 16'h0000, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [NCS-1:0]   cfg_fast, cfg_addr_hold;
  logic [NCS*2-1:0] cfg_oe_dly;
  logic [NCS*4-1:0] cfg_rd_lead, cfg_recovery, cfg_wr_hold, cfg_wr_wait, cfg_rd_wait;
  logic [NCS*8-1:0] cfg_wr_delta, cfg_rd_delta;
  logic [8:0]  bus_addr;
  logic [NCS-1:0] bus_cs_n;
  logic        bus_oe_n, bus_we_n, bus_avalid_n, bus_dq_oe;
  logic [15:0] bus_dq_o, bus_dq_i;

  for (genvar i = 0; i < NCS; i++) begin : g_cfg
    assign cfg_fast[i]           = FAST_C[i][0];
    assign cfg_addr_hold[i]      = AH_C[i][0];
    assign cfg_oe_dly[i*2 +: 2]  = 2'(OED_C[i]);
    assign cfg_rd_lead[i*4 +: 4] = 4'(RL_C[i]);
    assign cfg_recovery[i*4 +: 4]= 4'(REC_C[i]);
    assign cfg_wr_hold[i*4 +: 4] = 4'(WH_C[i]);
    assign cfg_wr_wait[i*4 +: 4] = 4'(WW_C[i]);
    assign cfg_rd_wait[i*4 +: 4] = 4'(RW_C[i]);
    assign cfg_wr_delta[i*8 +: 8]= 8'(WD_C[i]);
    assign cfg_rd_delta[i*8 +: 8]= 8'(RD_C[i]);
  end

  xbus_slow_cs_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_fast(cfg_fast), .cfg_addr_hold(cfg_addr_hold), .cfg_oe_dly(cfg_oe_dly),
    .cfg_rd_lead(cfg_rd_lead), .cfg_recovery(cfg_recovery), .cfg_wr_hold(cfg_wr_hold),
    .cfg_wr_wait(cfg_wr_wait), .cfg_rd_wait(cfg_rd_wait),
    .cfg_wr_delta(cfg_wr_delta), .cfg_rd_delta(cfg_rd_delta),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_avalid_n(bus_avalid_n), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
    .bus_dq_i(bus_dq_i)
  );

  function automatic int cs_index(input logic [NCS-1:0] csn);
    int idx = 7;
    for (int i = 0; i < NCS; i++) if (!csn[i]) idx = i;
    return idx;
  endfunction

  function automatic logic [15:0] mem_word(input int cs, input logic [8:0] a);
    return {3'(cs), a, 4'h5};
  endfunction

  // Device model: drives a known word whenever output enable is low.
  assign bus_dq_i = !bus_oe_n ? mem_word(cs_index(bus_cs_n), bus_addr) : 16'hDEAD;

  // Bus monitor: only running totals, sampled mid-cycle.
  int t_oe = 0, t_we = 0, t_hold = 0, t_rec = 0, t_adv = 0, t_bad = 0;
  logic [15:0] w_data = '0;
  logic [8:0]  w_addr = '0;
  int          w_cs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_oe_n) t_oe++;
      if (!bus_we_n) begin
        t_we++;
        w_data = bus_dq_oe ? bus_dq_o : 16'hBAD0;
        w_addr = bus_addr;
        w_cs   = cs_index(bus_cs_n);
      end
      if (bus_cs_n != '1 && bus_we_n && bus_dq_oe) t_hold++;
      if (!req_ready && bus_cs_n == '1) t_rec++;
      if (!bus_avalid_n) t_adv++;
      if (bus_dq_oe && (bus_cs_n == '1 || !bus_oe_n)) t_bad++;
      if (bus_dq_oe && bus_oe_n && bus_we_n && bus_cs_n != '1 && bus_dq_o !== req_wdata_q) t_bad++;
    end
  end

  logic [15:0] req_wdata_q = '0;

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;
  int last_cs = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(req_ready === 1'b1, tag, int'(req_ready), 1);
    chk(bus_cs_n === '1 && bus_oe_n === 1'b1 && bus_we_n === 1'b1 && bus_avalid_n === 1'b1,
        tag, int'({bus_cs_n, bus_oe_n, bus_we_n, bus_avalid_n}), 'h1FF);
    chk(bus_dq_oe === 1'b0 && rd_valid === 1'b0, tag, int'({bus_dq_oe, rd_valid}), 0);
  endtask

  task automatic run_vec(input vec_t v);
    int cs, a_len, h_len, r_len, g_len, lat, early, exp_lat;
    int s_oe, s_we, s_hold, s_rec, s_adv;
    string tl;
    cs    = int'(v.cs);
    a_len = 1 + (v.wr ? WW_C[cs] + (v.first ? WD_C[cs] : 0)
                      : RW_C[cs] + (v.first ? RD_C[cs] : 0));
    h_len = v.wr ? WH_C[cs] + 1 : 0;
    r_len = v.rec ? REC_C[last_cs] + 1 : 0;
    g_len = 0;
    if (FAST_C[cs] != 0) begin
      if (v.wr) g_len = AH_C[cs];
      else g_len = (RL_C[cs] > OED_C[cs] + AH_C[cs]) ? RL_C[cs] : OED_C[cs] + AH_C[cs];
    end
    exp_lat = r_len + 1 + g_len + a_len + h_len;
    while (!req_ready) begin @(posedge clk); #1; end
    req_write = v.wr; req_cs = v.cs; req_addr = v.addr; req_wdata = v.data;
    req_wdata_q = v.data;
    req_valid = 1'b1;
    s_oe = t_oe; s_we = t_we; s_hold = t_hold; s_rec = t_rec; s_adv = t_adv;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0; early = 0;
    while (lat < 2000) begin
      @(posedge clk); #1;
      lat++;
      if (v.wr ? req_ready : rd_valid) break;
      if (req_ready) early++;
    end
    tl = (FAST_C[cs] != 0) ? (v.wr ? "R10 latency" : "R9 latency")
                           : (v.wr ? "R4 latency" : "R3 latency");
    chk(lat == exp_lat, tl, lat, exp_lat);
    chk(early == 0 && req_ready === 1'b1, "R1 ready only when idle", early, 0);
    chk((v.wr ? t_we - s_we : t_oe - s_oe) == a_len,
        v.first ? "R6 strobe width first access" : "R3/R4 strobe width",
        v.wr ? t_we - s_we : t_oe - s_oe, a_len);
    chk(t_rec - s_rec == r_len, v.rec ? "R7 recovery" : "R8 no recovery", t_rec - s_rec, r_len);
    chk(t_adv - s_adv == 1, "R2 address valid once", t_adv - s_adv, 1);
    if (v.wr) begin
      chk(t_hold - s_hold == h_len, "R4 write hold", t_hold - s_hold, h_len);
      chk(w_data == v.data, "R5 write data", int'(w_data), int'(v.data));
      chk(w_addr == v.addr && w_cs == cs, "R2 write address/select",
          int'({w_cs[2:0], w_addr}), int'({v.cs, v.addr}));
    end else begin
      chk(rd_valid === 1'b1 && rd_data == mem_word(cs, v.addr), "R3 read data",
          int'(rd_data), int'(mem_word(cs, v.addr)));
      @(posedge clk); #1;
      chk(rd_valid === 1'b0, "R3 single valid pulse", int'(rd_valid), 0);
    end
    chk(t_bad == 0, "R5 data drive window", t_bad, 0);
    last_cs = cs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_idle("R11 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_idle("R11 after reset");

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // Reset in the middle of a read: bus returns idle, history is forgotten.
    req_write = 1'b0; req_cs = 3'd0; req_addr = 9'h010; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check_idle("R11 reset mid-access");
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_idle("R11 idle after mid-access reset");
    run_vec('{1'b0, 3'd0, 9'h010, 16'h0000, 1'b1, 1'b0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule